// File: doc/BRIEF.md
# Serial Controller Register Bank with Interrupt Identification

This block is the processor-facing register set of a PC-compatible serial controller. It sits on an 8-bit bus with a 3-bit offset and holds the configuration bytes: frame format, modem-line outputs, interrupt enables, the 16-bit baud divisor and a spare scratch byte. Receive data, line status and modem status come in from neighbouring logic and are passed through on reads. Reads and writes with side effects are reported to that logic as one-cycle strobes.

Four interrupt sources are combined into one prioritised identification byte and one interrupt line. The four sources are line errors, received data, transmitter ready and modem-line changes. A bit in the frame-format register switches offsets 0 and 1 over to the two divisor bytes, so the same bus window also programs the baud rate.

Reads are registered. `rd_data` and the read strobes appear in the cycle after the edge that samples `rd_en`. Writes take effect at the edge that samples `wr_en`.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous reset, the enable, format, modem-control, scratch and divisor registers read 0. Offset 2 reads 0x01 and `irq` is 0.
- R2: With format bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes, shown on `divisor`. With bit 7 clear, a write to offset 0 pulses `tx_push` with `tx_data`, and offset 1 is the enable register. Divisor writes never pulse `tx_push`.
- R3: Offset 1 stores only bits 3-0, which enable received data (bit 0), transmitter ready (bit 1), line status (bit 2) and modem status (bit 3). Bits 7-4 read 0.
- R4: Offset 2 bits 2-1 report the highest-priority enabled source, with codes line status 11 > received data 10 > transmitter ready 01 > modem status 00. Bit 0 is 0 while any enabled source is pending.
- R5: A source whose enable bit is clear never appears at offset 2 and never raises `irq`.
- R6: Offset 2 bits 7-6 read 11 while `fifo_on` is 1 and 00 otherwise. Bit 3 reads 1 together with code 10 when `rx_timeout` causes the report.
- R7: The transmitter-ready source is set by a rising edge of `thr_empty`. It is cleared by a read of offset 2 that reports it, or by a data write to offset 0.
- R8: `irq` equals modem-control bit 3 ANDed with "any enabled source pending", delayed by one clock.
- R9: Offset 7 reads back the last byte written to it, and writing it changes no other register or output.
- R10: Format register bits drive the outputs: bits 1-0 `word_len`, bit 2 `stop_sel`, bit 3 `even_par`, bit 4 `par_en`, bit 5 `stick_par`, bit 6 `brk`.
- R11: Modem-control bits 0 to 4 drive `dtr`, `rts`, `out1`, `out2` and `loop_en`. Bits 7-5 read 0.
- R12: Reading offset 0 with bit 7 clear returns `rx_data` and pulses `rx_pop`. Reading offset 5 returns `line_stat` and pulses `lsr_rd`. Reading offset 6 returns `modem_stat` and pulses `msr_rd`. Line-status sources are `line_stat` bits 4-1, and modem-status sources are `modem_stat` bits 3-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| rx_data | input | 8 | Received character |
| rx_ready | input | 1 | Received data available |
| rx_timeout | input | 1 | Receive timeout condition |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| thr_empty | input | 1 | Transmit holding register empty |
| fifo_on | input | 1 | FIFO mode active |
| tx_data | output | 8 | Byte to transmit |
| tx_push | output | 1 | Transmit write pulse |
| rx_pop | output | 1 | Received data read pulse |
| lsr_rd | output | 1 | Line status read pulse |
| msr_rd | output | 1 | Modem status read pulse |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Character length code |
| stop_sel | output | 1 | Stop-bit select |
| par_en | output | 1 | Parity enable |
| even_par | output | 1 | Even parity select |
| stick_par | output | 1 | Stick parity select |
| brk | output | 1 | Force break |
| dtr | output | 1 | DTR output |
| rts | output | 1 | RTS output |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2, gates `irq` |
| loop_en | output | 1 | Loopback enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 3-bit offset. At this size the divisor splits into exactly two bus bytes, so both latch offsets and the full 16-bit output can be checked against known values. Every offset of the map can be reached, including the status passthroughs and the ignored write to offset 2. Because all four interrupt sources sit within one 8-bit identification byte, the bench can walk through the whole priority order by removing sources one at a time. It can also see the timeout and FIFO flags in the same read.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IID  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_FMT  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LST  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MST  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;

  typedef enum logic [1:0] {
    SRC_MODEM = 2'b00,
    SRC_TXRDY = 2'b01,
    SRC_RXDAT = 2'b10,
    SRC_LINE  = 2'b11
  } irq_src_e;
endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int IEN_W  = 4,
  parameter int MCTL_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [IEN_W-1:0]    ien_q,
  output logic [DATA_W-1:0]   fmt_q,
  output logic [MCTL_W-1:0]   mctl_q,
  output logic [2*DATA_W-1:0] div_q,
  output logic [DATA_W-1:0]   scr_q
);
  localparam int DIV_W = 2 * DATA_W;

  logic latch_sel;
  assign latch_sel = fmt_q[DATA_W-1];

  logic wr_lo, wr_hi;
  assign wr_lo = wr_en && (addr == ADDR_W'(OFS_DATA));
  assign wr_hi = wr_en && (addr == ADDR_W'(OFS_IEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      fmt_q  <= '0;
      mctl_q <= '0;
      div_q  <= '0;
      scr_q  <= '0;
    end else begin
      if (wr_lo && latch_sel) div_q[DATA_W-1:0]     <= wr_data;
      if (wr_hi && latch_sel) div_q[DIV_W-1:DATA_W] <= wr_data;
      if (wr_hi && !latch_sel) ien_q <= wr_data[IEN_W-1:0];
      if (wr_en && addr == ADDR_W'(OFS_FMT))  fmt_q  <= wr_data;
      if (wr_en && addr == ADDR_W'(OFS_MCTL)) mctl_q <= wr_data[MCTL_W-1:0];
      if (wr_en && addr == ADDR_W'(OFS_SCR))  scr_q  <= wr_data;
    end
  end

  // R2: the divisor moves only on a latch-mode write to offset 0 or 1
  a_r2_div_stable: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && latch_sel && (addr == ADDR_W'(OFS_DATA) || addr == ADDR_W'(OFS_IEN)))
    |=> $stable(div_q));
endmodule

// File: rtl/uart_thre_track.sv
module uart_thre_track (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic clr_read,
  input  logic clr_write,
  output logic flag_q
);
  logic prev_q;
  logic rise;
  assign rise = thr_empty && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= thr_empty;
      if (rise)                       flag_q <= 1'b1;
      else if (clr_read || clr_write) flag_q <= 1'b0;
    end
  end

  // R7: a clear with no new rising edge leaves the source inactive
  a_r7_thre_clear: assert property (@(posedge clk) disable iff (rst)
    ((clr_read || clr_write) && !rise) |=> !flag_q);

  // R7: a rising edge of the empty flag always raises the source
  a_r7_thre_set: assert property (@(posedge clk) disable iff (rst)
    rise |=> flag_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regbank_pkg::*;
#(
  parameter int IEN_W = 4
) (
  input  logic [IEN_W-1:0] ien,
  input  logic             line_err,
  input  logic             rx_avail,
  input  logic             rx_tmo,
  input  logic             tx_rdy,
  input  logic             modem_chg,
  output irq_src_e         code,
  output logic             pend,
  output logic             tmo_flag
);
  logic [3:0] act;
  assign act[3] = ien[2] && line_err;
  assign act[2] = ien[0] && (rx_avail || rx_tmo);
  assign act[1] = ien[1] && tx_rdy;
  assign act[0] = ien[3] && modem_chg;

  always_comb begin
    code     = SRC_MODEM;
    tmo_flag = 1'b0;
    if (act[3])      code = SRC_LINE;
    else if (act[2]) begin
      code     = SRC_RXDAT;
      tmo_flag = rx_tmo;
    end
    else if (act[1]) code = SRC_TXRDY;
    pend = |act;
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   rx_data,
  input  logic                rx_ready,
  input  logic                rx_timeout,
  input  logic [DATA_W-1:0]   line_stat,
  input  logic [DATA_W-1:0]   modem_stat,
  input  logic                thr_empty,
  input  logic                fifo_on,
  output logic [DATA_W-1:0]   tx_data,
  output logic                tx_push,
  output logic                rx_pop,
  output logic                lsr_rd,
  output logic                msr_rd,
  output logic [2*DATA_W-1:0] divisor,
  output logic [1:0]          word_len,
  output logic                stop_sel,
  output logic                par_en,
  output logic                even_par,
  output logic                stick_par,
  output logic                brk,
  output logic                dtr,
  output logic                rts,
  output logic                out1,
  output logic                out2,
  output logic                loop_en,
  output logic                irq
);
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;
  localparam int DIV_W  = 2 * DATA_W;

  logic [IEN_W-1:0]  ien_q;
  logic [DATA_W-1:0] fmt_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] scr_q;

  uart_ctrl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IEN_W(IEN_W), .MCTL_W(MCTL_W)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ien_q(ien_q), .fmt_q(fmt_q), .mctl_q(mctl_q), .div_q(div_q), .scr_q(scr_q)
  );

  logic latch_sel;
  assign latch_sel = fmt_q[DATA_W-1];

  logic data_wr, data_rd, iid_rd;
  assign data_wr = wr_en && !latch_sel && (addr == ADDR_W'(OFS_DATA));
  assign data_rd = rd_en && !latch_sel && (addr == ADDR_W'(OFS_DATA));
  assign iid_rd  = rd_en && (addr == ADDR_W'(OFS_IID));

  irq_src_e code;
  logic     pend, tmo_flag, thre_q, thre_rd_clr;

  uart_irq_prio #(.IEN_W(IEN_W)) i_prio (
    .ien(ien_q),
    .line_err(|line_stat[4:1]),
    .rx_avail(rx_ready),
    .rx_tmo(rx_timeout),
    .tx_rdy(thre_q),
    .modem_chg(|modem_stat[3:0]),
    .code(code),
    .pend(pend),
    .tmo_flag(tmo_flag)
  );

  assign thre_rd_clr = iid_rd && pend && (code == SRC_TXRDY);

  uart_thre_track i_thre (
    .clk(clk), .rst(rst), .thr_empty(thr_empty),
    .clr_read(thre_rd_clr), .clr_write(data_wr), .flag_q(thre_q)
  );

  logic [DATA_W-1:0] iid_val;
  always_comb begin
    iid_val    = '0;
    iid_val[7] = fifo_on;
    iid_val[6] = fifo_on;
    iid_val[3] = tmo_flag;
    iid_val[2:1] = code;
    iid_val[0] = !pend;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_DATA): rd_mux = latch_sel ? div_q[DATA_W-1:0] : rx_data;
      ADDR_W'(OFS_IEN):  rd_mux = latch_sel ? div_q[DIV_W-1:DATA_W]
                                            : DATA_W'(ien_q);
      ADDR_W'(OFS_IID):  rd_mux = iid_val;
      ADDR_W'(OFS_FMT):  rd_mux = fmt_q;
      ADDR_W'(OFS_MCTL): rd_mux = DATA_W'(mctl_q);
      ADDR_W'(OFS_LST):  rd_mux = line_stat;
      ADDR_W'(OFS_MST):  rd_mux = modem_stat;
      default:           rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      tx_data <= '0;
      tx_push <= 1'b0;
      rx_pop  <= 1'b0;
      lsr_rd  <= 1'b0;
      msr_rd  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      if (data_wr) tx_data <= wr_data;
      tx_push <= data_wr;
      rx_pop  <= data_rd;
      lsr_rd  <= rd_en && (addr == ADDR_W'(OFS_LST));
      msr_rd  <= rd_en && (addr == ADDR_W'(OFS_MST));
      irq     <= mctl_q[3] && pend;
    end
  end

  assign divisor   = div_q;
  assign word_len  = fmt_q[1:0];
  assign stop_sel  = fmt_q[2];
  assign even_par  = fmt_q[3];
  assign par_en    = fmt_q[4];
  assign stick_par = fmt_q[5];
  assign brk       = fmt_q[6];
  assign dtr       = mctl_q[0];
  assign rts       = mctl_q[1];
  assign out1      = mctl_q[2];
  assign out2      = mctl_q[3];
  assign loop_en   = mctl_q[4];

  // R8: the request line is never high unless the gate bit was set a cycle before
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(out2));

  // R6: the timeout flag only accompanies the received-data code
  a_r6_tmo_code: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |-> (code == SRC_RXDAT) && pend);

  // R12: at most one read side-effect strobe per cycle
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_pop, lsr_rd, msr_rd}));

  // R2: a transmit push never follows a write made in divisor-latch mode
  a_r2_no_push_latch: assert property (@(posedge clk) disable iff (rst)
    (wr_en && latch_sel) |=> !tx_push);
endmodule

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] rx_data = '0;
  logic       rx_ready = 1'b0;
  logic       rx_timeout = 1'b0;
  logic [7:0] line_stat = '0;
  logic [7:0] modem_stat = '0;
  logic       thr_empty = 1'b1;
  logic       fifo_on = 1'b0;
  logic [7:0] tx_data;
  logic       tx_push, rx_pop, lsr_rd, msr_rd;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic       stop_sel, par_en, even_par, stick_par, brk;
  logic       dtr, rts, out1, out2, loop_en, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic s_pop, s_lsr, s_msr;

  always #2 clk = ~clk;

  uart_regbank i_uart_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .line_stat(line_stat), .modem_stat(modem_stat),
    .thr_empty(thr_empty), .fifo_on(fifo_on), .tx_data(tx_data),
    .tx_push(tx_push), .rx_pop(rx_pop), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .divisor(divisor), .word_len(word_len), .stop_sel(stop_sel),
    .par_en(par_en), .even_par(even_par), .stick_par(stick_par), .brk(brk),
    .dtr(dtr), .rts(rts), .out1(out1), .out2(out2), .loop_en(loop_en),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; s_pop = rx_pop; s_lsr = lsr_rd; s_msr = msr_rd;
  endtask

  task automatic pulse_empty();
    thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 divisor", divisor, 0);
    rd(3'd1, d); chk("R1 enable reg", d, 8'h00);
    rd(3'd2, d); chk("R1 ident reg", d, 8'h01);
    rd(3'd3, d); chk("R1 format reg", d, 8'h00);
    rd(3'd4, d); chk("R1 modem ctl", d, 8'h00);
    rd(3'd7, d); chk("R1 scratch", d, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk("R2 no push in latch mode", tx_push, 0);
    wr(3'd1, 8'h12);
    chk("R2 divisor value", divisor, 16'h1234);
    rd(3'd0, d); chk("R2 divisor low read", d, 8'h34);
    chk("R12 no pop in latch mode", s_pop, 0);
    rd(3'd1, d); chk("R2 divisor high read", d, 8'h12);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h05);
    rd(3'd1, d); chk("R2 enable reg when latch off", d, 8'h05);
    chk("R2 divisor kept", divisor, 16'h1234);
    wr(3'd0, 8'h5A);
    chk("R2 tx push", tx_push, 1);
    chk("R2 tx data", tx_data, 8'h5A);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_ier_bits();
    logic [7:0] d;
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R3 upper enable bits zero", d, 8'h0F);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(3'd1, 8'h0F);
    pulse_empty();
    line_stat = 8'h02; rx_ready = 1'b1; modem_stat = 8'h01;
    rd(3'd2, d); chk("R4 line status wins", d, 8'h06);
    line_stat = 8'h00;
    rd(3'd2, d); chk("R4 received data next", d, 8'h04);
    rx_ready = 1'b0;
    rd(3'd2, d); chk("R4 transmitter ready next", d, 8'h02);
    rd(3'd2, d); chk("R7 ident read clears tx ready", d, 8'h00);
    modem_stat = 8'h00;
    rd(3'd2, d); chk("R4 none pending", d, 8'h01);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(3'd4, 8'h08);
    wr(3'd1, 8'h00);
    line_stat = 8'h10; rx_ready = 1'b1; modem_stat = 8'h08;
    pulse_empty();
    rd(3'd2, d); chk("R5 disabled sources hidden", d, 8'h01);
    chk("R5 no irq", irq, 0);
    wr(3'd1, 8'h08);
    rd(3'd2, d); chk("R5 only modem enabled", d, 8'h00);
    tick();
    chk("R8 irq with gate set", irq, 1);
    wr(3'd4, 8'h00);
    tick();
    chk("R8 irq gated off", irq, 0);
    wr(3'd1, 8'h00);
    line_stat = 8'h00; rx_ready = 1'b0; modem_stat = 8'h00;
    wr(3'd0, 8'h00);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    wr(3'd1, 8'h01);
    fifo_on = 1'b1; rx_timeout = 1'b1;
    rd(3'd2, d); chk("R6 timeout with fifo", d, 8'hCC);
    rx_timeout = 1'b0;
    rd(3'd2, d); chk("R6 fifo idle", d, 8'hC1);
    fifo_on = 1'b0;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_thre_write();
    wr(3'd4, 8'h08);
    wr(3'd1, 8'h02);
    pulse_empty();
    tick();
    chk("R7 tx ready raises irq", irq, 1);
    wr(3'd0, 8'h11);
    tick();
    chk("R7 data write clears tx ready", irq, 0);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    wr(3'd3, 8'h00);
    wr(3'd7, 8'hA5);
    rd(3'd7, d); chk("R9 scratch readback", d, 8'hA5);
    rd(3'd3, d); chk("R9 format untouched", d, 8'h00);
    chk("R9 divisor untouched", divisor, 16'h1234);
  endtask

  task automatic t_format();
    logic [7:0] d;
    wr(3'd3, 8'h7B);
    rd(3'd3, d); chk("R10 format readback", d, 8'h7B);
    chk("R10 fields", {word_len, stop_sel, even_par, par_en, stick_par, brk},
        16'({2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}));
    wr(3'd3, 8'h04);
    chk("R10 stop select", {word_len, stop_sel, brk}, 16'({2'b00, 1'b1, 1'b0}));
    wr(3'd3, 8'h00);
  endtask

  task automatic t_modem();
    logic [7:0] d;
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R11 modem ctl upper zero", d, 8'h1F);
    chk("R11 pins", {loop_en, out2, out1, rts, dtr}, 16'h1F);
    wr(3'd4, 8'h05);
    chk("R11 pins partial", {loop_en, out2, out1, rts, dtr}, 16'h05);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    rx_data = 8'hC3; line_stat = 8'h61; modem_stat = 8'hB0;
    rd(3'd0, d); chk("R12 rx data", d, 8'hC3);
    chk("R12 rx pop", s_pop, 1);
    rd(3'd5, d); chk("R12 line status", d, 8'h61);
    chk("R12 lsr strobe", s_lsr, 1);
    rd(3'd6, d); chk("R12 modem status", d, 8'hB0);
    chk("R12 msr strobe", s_msr, 1);
    chk("R12 no stray pop", s_pop, 0);
    line_stat = 8'h00; modem_stat = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_ier_bits();
    t_priority();
    t_disabled();
    t_timeout();
    t_thre_write();
    t_scratch();
    t_format();
    t_modem();
    t_status();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule